// File: doc/BRIEF.md
# Three-Level Translation Table Walker

This block handles a translation-buffer miss by reading a three-level, forward-mapped translation table from memory. A virtual address of 43 bits carries three 10-bit table indices above a 13-bit byte offset. Privileged software loads a root register with the frame number of the first-level table, and reloads it whenever it switches context. The walker starts from that frame. At each level it forms an entry address from the current table frame and that level's index, and it issues one word read on a simple request/response memory port. A valid non-leaf entry supplies the frame of the next table.

When the third entry is valid and allows the pending access, the walker sends it to the translation-buffer fill port with the virtual page number. An entry whose valid bit is clear stops the walk and reports a not-mapped fault, together with the level where it was found. A valid leaf that does not allow the access reports a permission fault. A plain miss never raises a fault. Only one walk runs at a time. Writing the root register while a walk is in flight abandons that walk.

Top module: `ptw_walker`

## Requirements
- R1: While reset is high and in the cycle after it, `busy`, `mem_req_valid`, `fill_valid` and `fault_valid` are low.
- R2: The request for level L (0, 1, 2) has the address {table frame, index, 3'b000}, where the index is va[42:33] for L=0, va[32:23] for L=1 and va[22:13] for L=2.
- R3: The level-0 table frame is the root register. A root write takes effect for the next walk. A miss accepted in the same cycle as a root write uses the newly written frame.
- R4: Each successful walk makes exactly three reads. A valid non-leaf entry gives the next table frame in bits [39:13]. The fill reports the leaf entry unchanged on `fill_pte` and va[42:13] on `result_vpn`.
- R5: An entry with bit 0 (valid) clear at any level ends the walk with `fault_valid`, `fault_kind`=2'b01 and `fault_level` = that level. No fill occurs and no further read is issued.
- R6: The leaf is checked against the access code: 2'b00 read needs bit 1, 2'b01 write needs bit 2, 2'b10 execute needs bit 3, and 2'b11 is always refused. A refusal gives `fault_kind`=2'b10 with `fault_level`=2 and no fill. Permission bits of non-leaf entries are ignored.
- R7: `busy` rises in the cycle after a miss is accepted and stays high until the cycle of the result pulse. A miss presented while `busy` is high is ignored.
- R8: `fill_valid` and `fault_valid` are single-cycle pulses and are never high together.
- R9: A root write while `busy` is high abandons the walk: the next cycle is idle with no fill or fault, and a memory response arriving in the abort cycle is discarded.
- R10: Once raised, `mem_req_valid` stays high with a stable address until `mem_req_ready` is seen, unless the walk is aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_we | input | 1 | Root register write (context switch) |
| root_frame | input | 27 | Frame number of the first-level table |
| miss_valid | input | 1 | Translation-buffer miss request |
| miss_va | input | 43 | Missing virtual address |
| miss_acc | input | 2 | Access code: 00 read, 01 write, 10 execute, 11 reserved |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 40 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Table entry read |
| fill_valid | output | 1 | Fill pulse to the translation buffer |
| fill_pte | output | 64 | Leaf entry to install |
| result_vpn | output | 30 | Virtual page number of the finished walk |
| fault_valid | output | 1 | Fault pulse |
| fault_kind | output | 2 | 01 not mapped, 10 permission refused |
| fault_level | output | 2 | Level at which the walk stopped |

## Verification
The bench builds sparse tables in a memory model and walks addresses that are fully mapped for each access code. This separates the three permission bits from one another and from the reserved code. It also walks addresses with holes at level 0, level 1 and the leaf, so that a fault at one level cannot be mistaken for a fault at another. Walks with a stalling request port show whether the request is held correctly, and a miss pulsed during a walk shows whether the second request is really dropped. An abort timed to land exactly on a response, followed by walks under a new root (one of them started in the same cycle as the root write), shows whether the response is discarded and whether the root is taken at the right moment.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int IDX_W   = 10;
    localparam int OFS_W   = 13;
    localparam int LEVELS  = 3;
    localparam int VA_W    = LEVELS * IDX_W + OFS_W;
    localparam int VPN_W   = LEVELS * IDX_W;
    localparam int PA_W    = 40;
    localparam int PFN_W   = PA_W - OFS_W;
    localparam int PTE_W   = 64;
    localparam int ENT_SH  = OFS_W - IDX_W;
    localparam int LVL_W   = 2;

    localparam int BIT_V   = 0;
    localparam int BIT_RD  = 1;
    localparam int BIT_WR  = 2;
    localparam int BIT_EX  = 3;
    localparam int PFN_LSB = OFS_W;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_UNMAP  = 2'b01,
        FLT_PERM   = 2'b10
    } flt_e;

    typedef enum logic [1:0] {
        WS_IDLE = 2'b00,
        WS_REQ  = 2'b01,
        WS_WAIT = 2'b10
    } wstate_e;

    typedef struct packed {
        logic [VA_W-1:0]  va;
        acc_e             acc;
        logic [PFN_W-1:0] frame;
        logic [LVL_W-1:0] level;
    } walk_ctx_t;

    function automatic logic [PFN_W-1:0] next_frame(logic [PTE_W-1:0] pte);
        return pte[PFN_LSB +: PFN_W];
    endfunction

    function automatic logic [VPN_W-1:0] vpn_of(logic [VA_W-1:0] va);
        return va[VA_W-1:OFS_W];
    endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [PFN_W-1:0] frame,
    input  logic [VA_W-1:0]  va,
    input  logic [LVL_W-1:0] level,
    output logic [PA_W-1:0]  addr
);
    logic [IDX_W-1:0] idx_by_lvl [LEVELS];

    // Level 0 takes the topmost index field; deeper levels move toward the offset.
    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        localparam int LSB = OFS_W + (LEVELS - 1 - g) * IDX_W;
        assign idx_by_lvl[g] = va[LSB +: IDX_W];
    end

    logic [IDX_W-1:0] idx_sel;

    always_comb begin
        idx_sel = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (level == LVL_W'(i)) idx_sel = idx_by_lvl[i];
        end
    end

    assign addr = {frame, OFS_W'(0)} | (PA_W'(idx_sel) << ENT_SH);
endmodule

// File: rtl/ptw_perm_chk.sv
module ptw_perm_chk
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] pte,
    input  acc_e             acc,
    output logic             allow
);
    always_comb begin
        unique case (acc)
            ACC_READ:  allow = pte[BIT_RD];
            ACC_WRITE: allow = pte[BIT_WR];
            ACC_EXEC:  allow = pte[BIT_EX];
            default:   allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             root_we,
    input  logic [PFN_W-1:0] root_frame,
    input  logic             miss_valid,
    input  logic [VA_W-1:0]  miss_va,
    input  logic [1:0]       miss_acc,
    output logic             busy,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             fill_valid,
    output logic [PTE_W-1:0] fill_pte,
    output logic [VPN_W-1:0] result_vpn,
    output logic             fault_valid,
    output logic [1:0]       fault_kind,
    output logic [LVL_W-1:0] fault_level
);
    wstate_e          st;
    walk_ctx_t        ctx;
    logic [PFN_W-1:0] root_q;
    logic             leaf_ok;
    logic             at_leaf;
    flt_e             flt_q;

    ptw_addr_gen u_addr (
        .frame (ctx.frame),
        .va    (ctx.va),
        .level (ctx.level),
        .addr  (mem_req_addr)
    );

    ptw_perm_chk u_perm (
        .pte   (mem_rsp_data),
        .acc   (ctx.acc),
        .allow (leaf_ok)
    );

    assign at_leaf       = (ctx.level == LVL_W'(LEVELS - 1));
    assign busy          = (st != WS_IDLE);
    assign mem_req_valid = (st == WS_REQ);
    assign result_vpn    = vpn_of(ctx.va);
    assign fault_kind    = flt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= WS_IDLE;
            ctx         <= '0;
            root_q      <= '0;
            fill_valid  <= 1'b0;
            fill_pte    <= '0;
            fault_valid <= 1'b0;
            flt_q       <= FLT_NONE;
            fault_level <= '0;
        end else begin
            fill_valid  <= 1'b0;
            fault_valid <= 1'b0;
            if (root_we) root_q <= root_frame;

            unique case (st)
                WS_IDLE: begin
                    if (miss_valid) begin
                        ctx.va    <= miss_va;
                        ctx.acc   <= acc_e'(miss_acc);
                        ctx.frame <= root_we ? root_frame : root_q;
                        ctx.level <= '0;
                        st        <= WS_REQ;
                    end
                end
                WS_REQ: begin
                    if (root_we)            st <= WS_IDLE;
                    else if (mem_req_ready) st <= WS_WAIT;
                end
                WS_WAIT: begin
                    if (root_we) begin
                        st <= WS_IDLE;
                    end else if (mem_rsp_valid) begin
                        if (!mem_rsp_data[BIT_V]) begin
                            fault_valid <= 1'b1;
                            flt_q       <= FLT_UNMAP;
                            fault_level <= ctx.level;
                            st          <= WS_IDLE;
                        end else if (!at_leaf) begin
                            ctx.frame <= next_frame(mem_rsp_data);
                            ctx.level <= ctx.level + 1'b1;
                            st        <= WS_REQ;
                        end else if (leaf_ok) begin
                            fill_valid <= 1'b1;
                            fill_pte   <= mem_rsp_data;
                            st         <= WS_IDLE;
                        end else begin
                            fault_valid <= 1'b1;
                            flt_q       <= FLT_PERM;
                            fault_level <= ctx.level;
                            st          <= WS_IDLE;
                        end
                    end
                end
                default: st <= WS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
    import ptw_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            root_we,
    input logic            miss_valid,
    input logic            busy,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            fill_valid,
    input logic            fault_valid,
    input logic [1:0]      fault_kind
);
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !mem_req_valid && !fill_valid && !fault_valid));

    p_req_held_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready && !root_we) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_one_result_r8: assert property (@(posedge clk) disable iff (rst)
        !(fill_valid && fault_valid));

    p_fill_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> !fill_valid);

    p_fault_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        fault_valid |=> !fault_valid);

    p_fault_code_r5: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> (fault_kind == 2'b01 || fault_kind == 2'b10));

    p_abort_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (root_we && busy) |=> (!busy && !fill_valid && !fault_valid));

    p_start_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && miss_valid) |=> busy);

    p_idle_no_req_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req_valid);
endmodule

bind ptw_walker ptw_walker_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .root_we       (root_we),
    .miss_valid    (miss_valid),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .fill_valid    (fill_valid),
    .fault_valid   (fault_valid),
    .fault_kind    (fault_kind)
);

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
    import ptw_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             drv_we = 1'b0;
    logic [PFN_W-1:0] drv_root = '0;
    logic             abort_pulse = 1'b0;
    logic [PFN_W-1:0] abort_root = '0;
    logic             root_we;
    logic [PFN_W-1:0] root_frame;
    logic             miss_valid = 1'b0;
    logic [VA_W-1:0]  miss_va = '0;
    logic [1:0]       miss_acc = '0;
    logic             busy, mem_req_valid, fill_valid, fault_valid;
    logic             mem_req_ready = 1'b1;
    logic [PA_W-1:0]  mem_req_addr;
    logic             mem_rsp_valid = 1'b0;
    logic [PTE_W-1:0] mem_rsp_data = '0;
    logic [PTE_W-1:0] fill_pte;
    logic [VPN_W-1:0] result_vpn;
    logic [1:0]       fault_kind;
    logic [LVL_W-1:0] fault_level;

    assign root_we    = drv_we | abort_pulse;
    assign root_frame = abort_pulse ? abort_root : drv_root;

    always #5 clk = ~clk;

    ptw_walker dut_i (.*);

    typedef struct {
        bit               is_fault;
        logic [1:0]       kind;
        logic [LVL_W-1:0] lvl;
        logic [PTE_W-1:0] pte;
        logic [VPN_W-1:0] vpn;
        string            tag;
    } exp_t;

    exp_t             sb_q[$];
    logic [PTE_W-1:0] mem_tbl [logic [PA_W-1:0]];
    int               checks = 0;
    int               fails = 0;
    int               out_count = 0;
    int               req_count = 0;
    int               next_alloc = 'h200;
    bit               stall_mode = 0;
    bit               abort_next = 0;

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [PTE_W-1:0] rd(logic [PA_W-1:0] a);
        return mem_tbl.exists(a) ? mem_tbl[a] : '0;
    endfunction

    function automatic logic [VA_W-1:0] mkva(int i0, int i1, int i2);
        return {IDX_W'(i0), IDX_W'(i1), IDX_W'(i2), OFS_W'(0)};
    endfunction

    function automatic logic [PA_W-1:0] ent_addr(logic [PFN_W-1:0] f, logic [VA_W-1:0] va, int l);
        logic [IDX_W-1:0] ix;
        ix = IDX_W'(va >> (OFS_W + (2 - l) * IDX_W));
        return {f, ix, 3'b000};
    endfunction

    task automatic map_page(logic [PFN_W-1:0] root, logic [VA_W-1:0] va, logic [PTE_W-1:0] leaf);
        logic [PFN_W-1:0] f;
        logic [PA_W-1:0]  a;
        f = root;
        for (int l = 0; l < 2; l++) begin
            a = ent_addr(f, va, l);
            if (!rd(a)[0]) begin
                mem_tbl[a] = (PTE_W'(next_alloc) << OFS_W) | 64'h1;
                next_alloc++;
            end
            f = rd(a)[OFS_W +: PFN_W];
        end
        mem_tbl[ent_addr(f, va, 2)] = leaf;
    endtask

    function automatic exp_t model(logic [PFN_W-1:0] root, logic [VA_W-1:0] va, logic [1:0] acc, string tag);
        exp_t e;
        logic [PFN_W-1:0] f;
        logic [PTE_W-1:0] p;
        bit ok;
        e.tag = tag; e.vpn = va[VA_W-1:OFS_W]; e.pte = '0; e.kind = 2'b00; e.lvl = '0; e.is_fault = 0;
        f = root;
        for (int l = 0; l < 3; l++) begin
            p = rd(ent_addr(f, va, l));
            if (!p[0]) begin
                e.is_fault = 1; e.kind = 2'b01; e.lvl = LVL_W'(l);
                return e;
            end
            f = p[OFS_W +: PFN_W];
        end
        ok = (acc == 2'b00) ? p[1] : (acc == 2'b01) ? p[2] : (acc == 2'b10) ? p[3] : 1'b0;
        if (ok) e.pte = p;
        else begin e.is_fault = 1; e.kind = 2'b10; e.lvl = 2'd2; end
        return e;
    endfunction

    // Monitor: pops expectations as results appear.
    always @(posedge clk) begin
        #2;
        if (!rst && (fill_valid || fault_valid)) begin
            exp_t e;
            out_count++;
            if (sb_q.size() == 0) begin
                check(0, "R9/R7 unexpected result", {62'd0, fault_valid, fill_valid}, 64'd0);
            end else begin
                e = sb_q.pop_front();
                check(fill_valid != fault_valid, {e.tag, " R8 single pulse"}, {62'd0, fault_valid, fill_valid}, {62'd0, e.is_fault, !e.is_fault});
                check(fault_valid == e.is_fault, {e.tag, " R5/R6 outcome"}, 64'(fault_valid), 64'(e.is_fault));
                check(result_vpn == e.vpn, {e.tag, " R4 vpn"}, 64'(result_vpn), 64'(e.vpn));
                if (e.is_fault) begin
                    check(fault_kind == e.kind, {e.tag, " R5/R6 kind"}, 64'(fault_kind), 64'(e.kind));
                    check(fault_level == e.lvl, {e.tag, " R5 level"}, 64'(fault_level), 64'(e.lvl));
                end else begin
                    check(fill_pte == e.pte, {e.tag, " R4 fill pte"}, fill_pte, e.pte);
                end
            end
        end
    end

    // Memory model: two-cycle read latency, optional request stalls.
    initial begin
        int cnt = 0;
        int cyc = 0;
        logic [PA_W-1:0] pa = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            abort_pulse   = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(pa);
                    if (abort_next) begin
                        abort_pulse = 1'b1;
                        abort_next  = 0;
                    end
                end
            end
            mem_req_ready = stall_mode ? (cyc % 3 == 2) : 1'b1;
            cyc++;
            if (mem_req_valid && mem_req_ready) begin
                cnt = 2;
                pa  = mem_req_addr;
                req_count++;
            end
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // Driver: pushes the expected result, then issues the miss.
    task automatic walk(logic [PFN_W-1:0] root, logic [VA_W-1:0] va, logic [1:0] acc, string tag, int exp_reads);
        int r0;
        wait_idle();
        sb_q.push_back(model(root, va, acc, tag));
        r0 = req_count;
        miss_valid = 1'b1; miss_va = va; miss_acc = acc;
        @(negedge clk);
        miss_valid = 1'b0;
        check(busy == 1'b1, {tag, " R7 busy after miss"}, 64'(busy), 64'd1);
        wait_idle();
        check(req_count - r0 == exp_reads, {tag, " R4/R5 read count"}, 64'(req_count - r0), 64'(exp_reads));
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", checks);
        finish_run();
    end

    initial begin
        logic [PFN_W-1:0] rootA = 'h100;
        logic [PFN_W-1:0] rootB = 'h300;
        logic [PTE_W-1:0] pteA  = (64'h4_0001 << OFS_W) | 64'b0011; // R only
        logic [PTE_W-1:0] pteB  = (64'h4_0002 << OFS_W) | 64'b1001; // X only
        logic [PTE_W-1:0] pteC  = (64'h4_0003 << OFS_W) | 64'b0101; // W only
        logic [PTE_W-1:0] pteD  = (64'h4_0004 << OFS_W) | 64'b1110; // invalid leaf
        logic [PTE_W-1:0] pteE  = (64'h5_0005 << OFS_W) | 64'b0111; // under rootB
        int oc;

        map_page(rootA, mkva(1, 2, 3), pteA);
        map_page(rootA, mkva(1, 2, 1023), pteB);
        map_page(rootA, mkva(1023, 0, 7), pteC);
        map_page(rootA, mkva(5, 9, 9), pteD);
        map_page(rootB, mkva(1, 2, 3), pteE);

        repeat (3) @(negedge clk);
        check(!busy && !mem_req_valid && !fill_valid && !fault_valid, "R1 reset outputs",
              {60'd0, busy, mem_req_valid, fill_valid, fault_valid}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !mem_req_valid, "R1 after reset", {62'd0, busy, mem_req_valid}, 64'd0);

        drv_we = 1'b1; drv_root = rootA;
        @(negedge clk);
        drv_we = 1'b0;

        walk(rootA, mkva(1, 2, 3), 2'b00, "R2 R6 read allowed", 3);
        walk(rootA, mkva(1, 2, 3), 2'b01, "R6 write refused", 3);
        walk(rootA, mkva(1, 2, 1023), 2'b10, "R6 exec allowed", 3);
        walk(rootA, mkva(1, 2, 1023), 2'b00, "R6 read refused on exec page", 3);
        walk(rootA, mkva(1023, 0, 7), 2'b01, "R2 R6 write allowed high index", 3);
        walk(rootA, mkva(1023, 0, 7), 2'b11, "R6 reserved code refused", 3);
        walk(rootA, mkva(6, 0, 0), 2'b00, "R5 hole at level 0", 1);
        walk(rootA, mkva(1, 3, 3), 2'b00, "R5 hole at level 1", 2);
        walk(rootA, mkva(5, 9, 9), 2'b10, "R5 invalid leaf", 3);

        stall_mode = 1;
        walk(rootA, mkva(1, 2, 3), 2'b00, "R10 stalled request", 3);
        walk(rootA, mkva(1023, 0, 7), 2'b01, "R10 stalled request 2", 3);
        stall_mode = 0;

        // R7: a second miss during a walk is dropped.
        wait_idle();
        oc = out_count;
        sb_q.push_back(model(rootA, mkva(1, 2, 1023), 2'b10, "R7 first walk"));
        miss_valid = 1'b1; miss_va = mkva(1, 2, 1023); miss_acc = 2'b10;
        @(negedge clk);
        miss_va = mkva(6, 0, 0); miss_acc = 2'b00;
        @(negedge clk);
        miss_valid = 1'b0;
        wait_idle();
        repeat (8) @(negedge clk);
        check(out_count - oc == 1, "R7 busy miss ignored", 64'(out_count - oc), 64'd1);
        check(busy == 1'b0, "R7 no second walk", 64'(busy), 64'd0);

        // R9: abort coincident with the first response.
        oc = out_count;
        abort_root = rootB;
        abort_next = 1;
        miss_valid = 1'b1; miss_va = mkva(1, 2, 3); miss_acc = 2'b00;
        @(negedge clk);
        miss_valid = 1'b0;
        wait_idle();
        repeat (8) @(negedge clk);
        check(out_count == oc, "R9 abort discards response", 64'(out_count - oc), 64'd0);
        check(busy == 1'b0, "R9 idle after abort", 64'(busy), 64'd0);

        // R3: the aborting write installed the new root.
        walk(rootB, mkva(1, 2, 3), 2'b01, "R3 new root after switch", 3);

        // R3: root write in the same cycle as the miss.
        wait_idle();
        sb_q.push_back(model(rootA, mkva(1, 2, 3), 2'b00, "R3 same-cycle root"));
        drv_we = 1'b1; drv_root = rootA;
        miss_valid = 1'b1; miss_va = mkva(1, 2, 3); miss_acc = 2'b00;
        @(negedge clk);
        drv_we = 1'b0; miss_valid = 1'b0;
        wait_idle();

        repeat (6) @(negedge clk);
        check(sb_q.size() == 0, "R8 all results seen", 64'(sb_q.size()), 64'd0);
        finish_run();
    end
endmodule